// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a synchronous serial slave that lets a host reach a bank of 32 eight-bit control registers. The register storage itself sits outside the block. The block drives a single address, a one-cycle write strobe and write data toward that storage, and it reads back combinational read data on the same address.

Each exchange opens with an instruction byte that carries three things: the direction, how many data bytes follow (one to four), and the first register address. The block then moves the data bytes. After each byte it steps the address down by one, wrapping modulo 32. Data moves most significant bit first. Input bits are captured on rising serial clock edges, and read bits are launched on falling edges.

An active-low select gates the port. When the select goes inactive partway through an exchange, the exchange is frozen, not cancelled, and it carries on once the select returns. The select may also stay low permanently, in which case exchanges are framed only by counting bits. Bit 7 of register 0 chooses where read data leaves the block:
- When it is 0, read data goes out on the shared data pin.
- When it is 1, read data goes out on a dedicated output, and the shared pin becomes input only.

All host pins are brought into a faster system clock through two-flop synchronizers. Serial clock rates up to 5 MHz are supported when the system clock is at least about eight times that rate.

Top module: `ibs_port`

## Requirements
- R1: The instruction byte is decoded as follows. Bit 7 gives the direction (1 means read, 0 means write). Bits 6:5 give the data byte count minus one (00 means 1, 01 means 2, 10 means 3, 11 means 4). Bits 4:0 give the first register address.
- R2: In a write exchange, each data byte produces exactly one `rf_we` pulse after its eighth bit. The pulse carries that byte, and the addresses are start, start-1, start-2 and so on, modulo 32.
- R3: In a read exchange, each data byte is the register content at start, start-1, and so on (modulo 32). It is shifted out MSB first, with each bit changing after a falling serial clock edge.
- R4: After the encoded number of data bytes, the next eight bits are taken as a new instruction byte, with no select toggle needed. Both output enables are low outside the data bytes of a read.
- R5: While `cs_n` is high, `sdio_oe` and `sdo_oe` are both low.
- R6: Raising `cs_n` in the middle of an exchange keeps the bit position, byte position, address and direction. The exchange continues from that point when `cs_n` falls again.
- R7: Register 0 bit 7 selects the read pin. With 0, read data appears on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low. With 1, read data appears on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low. A write to register 0 changes the mode for the exchanges that follow it.
- R8: Synchronous reset returns the block to waiting for an instruction byte, clears the pin-mode bit to 0, and leaves both output enables and `rf_we` low.
- R9: Serial clock edges and data values that arrive while `cs_n` is high have no effect on the exchange in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe | output | 1 | Shared data pin drive enable |
| sdo_o | output | 1 | Dedicated read data output |
| sdo_oe | output | 1 | Dedicated read output drive enable |
| rf_addr | output | AW | Register file address |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | DW | Register file write data |
| rf_rdata | input | DW | Register file read data at `rf_addr` |

## Verification
Two functions can fall in the same cycle: a write that commits to register 0, and the pin-mode selection that decides which enable the next read raises. Other pairs also coincide:
- A select pause can land on the instruction-to-data boundary.
- Within a burst, a byte completion and the address wrap from 0 to 31 can occur together.

The bench provokes these cases with bursts that cross address 0, writes that flip the mode inside a burst, and pauses placed on chosen bit indices. A behavioural register image and a queue of expected write strobes judge every cycle. A per-clock monitor checks the enables against the mode that the model has committed so far.

// File: rtl/ibs_port.sv
module ibs_port #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe,
  output logic          sdo_o,
  output logic          sdo_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int BW = $clog2(DW);

  logic [2:0]    sclk_q;
  logic [1:0]    cs_q, dio_q;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg, tx;
  logic [1:0]    left;
  logic [AW-1:0] addr, wa;
  logic          phase, rd, mode, dout;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      dio_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      dio_q  <= {dio_q[0], sdio_i};
    end
  end

  wire           act  = ~cs_q[1];
  wire           rise = act & sclk_q[1] & ~sclk_q[2];
  wire           fall = act & ~sclk_q[1] & sclk_q[2];
  wire           done = rise & (bitcnt == BW'(DW - 1));
  wire [DW-1:0]  nxt  = {shreg[DW-2:0], dio_q[1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0; bitcnt <= '0; shreg <= '0; rd <= 1'b0; left <= '0;
      addr <= '0; wa <= '0; mode <= 1'b0; rf_we <= 1'b0; rf_wdata <= '0;
      tx <= '0; dout <= 1'b0;
    end else begin
      rf_we <= 1'b0;
      if (rise) begin
        shreg  <= nxt;
        bitcnt <= bitcnt + 1'b1;
      end
      if (done) begin
        if (!phase) begin
          rd    <= nxt[DW-1];
          left  <= nxt[DW-2 -: 2];
          addr  <= nxt[AW-1:0];
          phase <= 1'b1;
        end else begin
          if (!rd) begin
            rf_we    <= 1'b1;
            wa       <= addr;
            rf_wdata <= nxt;
            if (addr == '0) mode <= nxt[DW-1];
          end
          if (left == 2'd0) phase <= 1'b0;
          else left <= left - 1'b1;
          addr <= addr - 1'b1;
        end
      end
      if (fall && phase && rd) begin
        if (bitcnt == '0) begin
          dout <= rf_rdata[DW-1];
          tx   <= {rf_rdata[DW-2:0], 1'b0};
        end else begin
          dout <= tx[DW-1];
          tx   <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end

  wire oe = ~cs_n & phase & rd;
  assign sdio_oe = oe & ~mode;
  assign sdo_oe  = oe & mode;
  assign sdio_o  = dout;
  assign sdo_o   = dout;
  assign rf_addr = rf_we ? wa : addr;

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    cs_q[1] |=> ($stable(bitcnt) && $stable(phase) && $stable(addr) && $stable(left)));
  p_we_dir_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !rd);
  p_we_single_r2: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);
  p_burst_step_r2: assert property (@(posedge clk) disable iff (rst)
    (done && phase && left != 2'd0) |=> (addr == AW'($past(addr) - 1'b1)));
  p_read_steady_r3: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(dout));
  p_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (!phase && bitcnt == '0 && !mode && !rf_we));
endmodule

// File: tb/ibs_port_tb_top.sv
module ibs_port_tb_top;
  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, rf_we;
  logic [4:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] rf_mem [32];
  logic [7:0] exp_mem [32];
  bit exp_mode = 1'b0;
  int wq[$];
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ibs_port dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf_mem[i] <= 8'h00;
    end else if (rf_we) begin
      rf_mem[rf_addr] <= rf_wdata;
    end
  end
  assign rf_rdata = rf_mem[rf_addr];

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rf_we) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R2 unexpected write", {rf_addr, rf_wdata}, 0);
        end else begin
          int e;
          e = wq.pop_front();
          chk({rf_addr, rf_wdata} == e[12:0], "R2 write addr/data", {rf_addr, rf_wdata}, e);
          if (e[12:8] == 5'd0) exp_mode = e[7];
        end
      end
      if (cs_n) chk(!(sdio_oe || sdo_oe), "R5 enables with cs_n high", {sdio_oe, sdo_oe}, 0);
      if (sdio_oe || sdo_oe)
        chk(exp_mode ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe), "R7 read pin choice",
            {sdio_oe, sdo_oe}, exp_mode ? 1 : 2);
    end
  end

  task automatic wbit(bit b);
    @(negedge clk);
    sdio_i = b;
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rbit(output bit b, output bit pin_ok);
    @(negedge clk);
    sdio_i = $urandom_range(0, 1);
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    b = exp_mode ? sdo_o : sdio_o;
    pin_ok = exp_mode ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pause();
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      sclk = 1'b0; sdio_i = ~sdio_i;
      repeat (6) @(negedge clk);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk(!(sdio_oe || sdo_oe), "R5 enables during pause", {sdio_oe, sdo_oe}, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(bit rd, int n, int a0, logic [31:0] d, int pause_at);
    logic [7:0] ins;
    int k;
    ins = {rd, 2'(n - 1), 5'(a0)};
    k = 0;
    for (int i = 7; i >= 0; i--) begin
      if (k == pause_at) pause();
      wbit(ins[i]);
      k++;
    end
    for (int j = 0; j < n; j++) begin
      int a;
      logic [7:0] v;
      bit pins;
      a = (a0 - j) & 31;
      if (!rd) begin
        v = d[8*j +: 8];
        wq.push_back((a << 8) | v);
        exp_mem[a] = v;
        for (int i = 7; i >= 0; i--) begin
          if (k == pause_at) pause();
          wbit(v[i]);
          k++;
        end
      end else begin
        pins = 1'b1;
        for (int i = 7; i >= 0; i--) begin
          bit b, p;
          if (k == pause_at) pause();
          rbit(b, p);
          v[i] = b;
          pins &= p;
          k++;
        end
        chk(v == exp_mem[a], "R3 read byte (R1 decode)", v, exp_mem[a]);
        chk(pins, "R7 enable on selected pin for whole byte", pins, 1);
      end
    end
    repeat (4) @(negedge clk);
    chk(!(sdio_oe || sdo_oe), "R4 enables low after burst", {sdio_oe, sdo_oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!(sdio_oe || sdo_oe) && !rf_we, "R8 reset outputs", {sdio_oe, sdo_oe, rf_we}, 0);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    xfer(1'b0, 1, 5, 32'h0000_00A5, -1);
    xfer(1'b1, 1, 5, 32'h0, -1);
    xfer(1'b0, 4, 2, 32'hC311_5A3C, -1);
    xfer(1'b1, 4, 1, 32'h0, -1);
    xfer(1'b0, 3, 20, 32'h00F0_6996, 13);
    xfer(1'b1, 2, 20, 32'h0, 10);
    xfer(1'b0, 1, 0, 32'h0000_0080, -1);
    chk(exp_mode == 1'b1, "R7 mode committed by register 0 write", exp_mode, 1);
    xfer(1'b1, 2, 0, 32'h0, 20);
    xfer(1'b0, 2, 1, 32'h0000_017E, 8);
    chk(exp_mode == 1'b0, "R7 mode cleared inside burst", exp_mode, 0);
    xfer(1'b1, 3, 2, 32'h0, 3);
    repeat (10) @(negedge clk);
    chk(wq.size() == 0, "R2 all expected writes seen (R6 R9 after pauses)", wq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule